// File: doc/BRIEF.md
# Double-Buffered Colour Table Programming Port

This block is the software-facing register bank of a colour lookup table that is split across a set of sub-RAMs. A processor reaches it through a plain memory-mapped port with byte addresses, a write strobe, a read strobe and 32-bit data. Through it, software turns the table on or off for the video path, chooses which of two table copies the video path reads, and loads table entries one at a time. Read-only words report the build settings the table was generated with.

Loading an entry takes two steps. Software places the entry's bits in a pair of staging words (low 32 bits, then the remaining high bits), then writes the sub-RAM's command word with the entry index and a commit bit. The commit drives a single-cycle write strobe on that sub-RAM's write port, carrying the staged bits. The commit bit is never held, so it always reads back as zero. In the double-buffered build, every commit lands in the copy the video path is not reading. A change of the copy select reaches the video path only on a start-of-frame pulse. When readback is built in, the staging words read back the sub-RAM contents at the held index instead of the staged bits.

The sub-RAMs themselves sit outside this block. Each provides one write port and one read port with a single cycle of read latency.

Top module: `lut_prog_regs`

## Requirements
- R1: After reset `tbl_enable`, `tbl_active_buf` and every `ram_we` bit are 0, `reg_rdata` is 0, and the control word at 0x148 reads 0.
- R2: Read-only words return the build settings: 0x000 `BLOCK_ID`, 0x004 `BLOCK_VER`, 0x00C `PIX_PAR`, 0x010 `IN_BPS`, 0x014 `OUT_BPS`, 0x018 `ALPHA`, 0x01C `DEPTH`, 0x020 `DIM`, 0x024 `DOUBLE_BUF`, 0x028 `READBACK`.
- R3: A write to 0x148 stores bit 0 (1 applies the table, 0 bypasses it) and bit 1 (copy select). `tbl_enable` follows bit 0 from the next cycle. A read of 0x148 returns {30'b0, select, enable}.
- R4: With `DOUBLE_BUF`=1, `tbl_active_buf` takes the stored copy select only in the cycle after `sof` is high, and it holds its value at all other times.
- R5: A write to the command word 0x180+0x10*n with bit 28 set raises `ram_we[n]` in the next cycle for exactly one cycle. During that cycle the port drives `ram_waddr` slice n = {copy bit, entry index bits RAM_AW-1:0 of the written value} and `ram_wdata` slice n = the staged entry. A command write with bit 28 clear only updates the held index. At most one `ram_we` bit is high in any cycle.
- R6: A read of the command word returns the held index in bits 16:0. Bits 31:17 read 0, including the commit bit 28.
- R7: An entry is (ALPHA+3)*DEPTH bits wide. Staging word 0x188+0x10*n holds entry bits 31:0, and 0x18C+0x10*n holds the bits above 31. Written bits beyond the entry width are dropped and read 0. If the entry is 32 bits or narrower, the high word reads 0.
- R8: With `READBACK`=1, `ram_raddr` slice n = {copy bit, held index}. Reads of 0x188/0x18C+0x10*n then return sub-RAM n's output data, zero-extended and split as in R7.
- R9: With `DOUBLE_BUF`=1, the copy bit used for commits and readback is the inverse of `tbl_active_buf`.
- R10: Reads of reserved offsets (0x008, 0x02C-0x147, 0x14C-0x17F, 0x184+0x10*n) return 0. Writes to those offsets, and to read-only words, change no readable value and no output.
- R11: With `DOUBLE_BUF`=0, `tbl_active_buf` stays 0 and commits use copy bit 0. With `READBACK`=0, the staging words read back the staged bits.
- R12: `reg_rdata` carries the addressed word in the cycle after `reg_read` is high. In any cycle not preceded by a read it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 9 | Byte address of the register access |
| reg_write | input | 1 | Write strobe |
| reg_read | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| sof | input | 1 | Start-of-frame pulse from the video path |
| tbl_enable | output | 1 | 1 applies the table, 0 bypasses it |
| tbl_active_buf | output | 1 | Copy the video path reads |
| ram_we | output | NRAM | Per-sub-RAM write strobe |
| ram_waddr | output | NRAM*(RAM_AW+1) | Per-sub-RAM write address, copy bit on top |
| ram_wdata | output | NRAM*(ALPHA+3)*DEPTH | Per-sub-RAM write data |
| ram_raddr | output | NRAM*(RAM_AW+1) | Per-sub-RAM read address, copy bit on top |
| ram_rdata | input | NRAM*(ALPHA+3)*DEPTH | Per-sub-RAM read data, one cycle after the address |

## Verification
A wrong copy bit in the block shows up one cycle after a commit, as a write-port address aimed at the copy the video path is reading. It shows up again a few cycles later, when readback returns data from the other copy. A staging word or held index that was corrupted is only exposed when its entry is committed or read back. For that reason every staging and command word is followed by a commit and a readback of a known value. A stuck or spurious swap of the active copy appears on `tbl_active_buf` in the very cycle it happens, so that output is compared against an independent model on every clock.

// File: rtl/lutp_pkg.sv
package lutp_pkg;
  localparam int REG_AW = 9;   // byte address width of the register port
  localparam int ENT_AW = 17;  // width of the entry-index field in a command word
  localparam int WE_BIT = 28;  // commit bit in a command word

  localparam logic [REG_AW-1:0] OFS_ID    = 9'h000;
  localparam logic [REG_AW-1:0] OFS_VER   = 9'h004;
  localparam logic [REG_AW-1:0] OFS_PIX   = 9'h00C;
  localparam logic [REG_AW-1:0] OFS_IBPS  = 9'h010;
  localparam logic [REG_AW-1:0] OFS_OBPS  = 9'h014;
  localparam logic [REG_AW-1:0] OFS_ALPHA = 9'h018;
  localparam logic [REG_AW-1:0] OFS_DEPTH = 9'h01C;
  localparam logic [REG_AW-1:0] OFS_DIM   = 9'h020;
  localparam logic [REG_AW-1:0] OFS_DBUF  = 9'h024;
  localparam logic [REG_AW-1:0] OFS_RDBK  = 9'h028;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 9'h148;

  // word slot inside one 16-byte sub-RAM window
  typedef enum logic [1:0] {
    SLOT_CMD  = 2'd0,
    SLOT_RSVD = 2'd1,
    SLOT_LO   = 2'd2,
    SLOT_HI   = 2'd3
  } slot_e;

  typedef struct packed {
    logic       is_ram;
    logic [2:0] idx;
    slot_e      slot;
  } ram_dec_t;

  // sub-RAM windows live at 0x180..0x1FF, word aligned
  function automatic ram_dec_t decode_ram(input logic [REG_AW-1:0] a);
    ram_dec_t d;
    d.is_ram = (a[8:7] == 2'b11) && (a[1:0] == 2'b00);
    d.idx    = a[6:4];
    d.slot   = slot_e'(a[3:2]);
    return d;
  endfunction
endpackage

// File: rtl/lutp_ctrl.sv
module lutp_ctrl #(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [1:0] wbits,
  input  logic       sof,
  output logic       en,
  output logic       sel,
  output logic       act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      sel <= 1'b0;
    end else if (wr_ctrl) begin
      en  <= wbits[0];
      sel <= wbits[1];
    end
  end

  generate
    if (DOUBLE_BUF) begin : g_dbl
      // select reaches the video path only at a frame boundary
      always_ff @(posedge clk) begin
        if (rst)      act <= 1'b0;
        else if (sof) act <= sel;
      end
    end else begin : g_sgl
      assign act = 1'b0;
      logic unused_sof;
      assign unused_sof = sof ^ clk ^ rst;
    end
  endgenerate
endmodule

// File: rtl/lutp_ram_port.sv
module lutp_ram_port import lutp_pkg::*; #(
  parameter int RAM_AW  = 6,
  parameter int ENTRY_W = 36,
  localparam int LO_W = (ENTRY_W > 32) ? 32 : ENTRY_W,
  localparam int HI_W = ENTRY_W - LO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_cmd,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wbuf,
  input  logic [31:0]        wdata,
  output logic [ENT_AW-1:0]  eaddr,
  output logic [ENTRY_W-1:0] stage,
  output logic               we,
  output logic [RAM_AW:0]    waddr,
  output logic [ENTRY_W-1:0] wd,
  output logic [RAM_AW:0]    raddr
);
  logic [LO_W-1:0] stage_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      eaddr    <= '0;
      stage_lo <= '0;
      we       <= 1'b0;
      waddr    <= '0;
      wd       <= '0;
    end else begin
      we <= 1'b0;
      if (wr_cmd) begin
        eaddr <= wdata[ENT_AW-1:0];
        if (wdata[WE_BIT]) begin
          we    <= 1'b1;
          waddr <= {wbuf, wdata[RAM_AW-1:0]};
          wd    <= stage;
        end
      end
      if (wr_lo) stage_lo <= wdata[LO_W-1:0];
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] stage_hi;
      always_ff @(posedge clk) begin
        if (rst)        stage_hi <= '0;
        else if (wr_hi) stage_hi <= wdata[HI_W-1:0];
      end
      assign stage = {stage_hi, stage_lo};
    end else begin : g_nohi
      assign stage = stage_lo;
      logic unused_hi;
      assign unused_hi = wr_hi;
    end
  endgenerate

  assign raddr = {wbuf, eaddr[RAM_AW-1:0]};

  logic unused_wd;
  assign unused_wd = ^wdata;
endmodule

// File: rtl/lut_prog_regs.sv
module lut_prog_regs import lutp_pkg::*; #(
  parameter int          NRAM       = 8,
  parameter int          RAM_AW     = 6,
  parameter int          PIX_PAR    = 1,
  parameter int          IN_BPS     = 10,
  parameter int          OUT_BPS    = 10,
  parameter int          ALPHA      = 0,
  parameter int          DEPTH      = 12,
  parameter int          DIM        = 17,
  parameter bit          DOUBLE_BUF = 1'b1,
  parameter bit          READBACK   = 1'b1,
  parameter logic [31:0] BLOCK_ID   = 32'h3D1C_0A00,
  parameter logic [31:0] BLOCK_VER  = 32'h0001_0002,
  localparam int ENTRY_W = (ALPHA + 3) * DEPTH,
  localparam int RA_W    = RAM_AW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic                    reg_write,
  input  logic                    reg_read,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    sof,
  output logic                    tbl_enable,
  output logic                    tbl_active_buf,
  output logic [NRAM-1:0]         ram_we,
  output logic [NRAM*RA_W-1:0]    ram_waddr,
  output logic [NRAM*ENTRY_W-1:0] ram_wdata,
  output logic [NRAM*RA_W-1:0]    ram_raddr,
  input  logic [NRAM*ENTRY_W-1:0] ram_rdata
);
  ram_dec_t dec;
  logic en, sel, act, wbuf;
  logic [31:0] rd_nxt;
  logic [ENT_AW-1:0] eaddr [NRAM];
  logic [31:0] lo_v [NRAM];
  logic [31:0] hi_v [NRAM];

  assign dec = decode_ram(reg_addr);

  lutp_ctrl #(.DOUBLE_BUF(DOUBLE_BUF)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_ctrl(reg_write && (reg_addr == OFS_CTRL)),
    .wbits  (reg_wdata[1:0]),
    .sof    (sof),
    .en     (en),
    .sel    (sel),
    .act    (act)
  );

  assign tbl_enable     = en;
  assign tbl_active_buf = act;

  generate
    if (DOUBLE_BUF) begin : g_wb_dbl
      assign wbuf = ~act;
    end else begin : g_wb_sgl
      assign wbuf = 1'b0;
    end

    for (genvar g = 0; g < NRAM; g++) begin : g_ram
      logic               hit;
      logic [ENTRY_W-1:0] stage, src;
      logic [63:0]        wide;

      assign hit = reg_write && dec.is_ram && (dec.idx == 3'(g));

      lutp_ram_port #(.RAM_AW(RAM_AW), .ENTRY_W(ENTRY_W)) u_port (
        .clk   (clk),
        .rst   (rst),
        .wr_cmd(hit && (dec.slot == SLOT_CMD)),
        .wr_lo (hit && (dec.slot == SLOT_LO)),
        .wr_hi (hit && (dec.slot == SLOT_HI)),
        .wbuf  (wbuf),
        .wdata (reg_wdata),
        .eaddr (eaddr[g]),
        .stage (stage),
        .we    (ram_we[g]),
        .waddr (ram_waddr[g*RA_W +: RA_W]),
        .wd    (ram_wdata[g*ENTRY_W +: ENTRY_W]),
        .raddr (ram_raddr[g*RA_W +: RA_W])
      );

      if (READBACK) begin : g_rb
        assign src = ram_rdata[g*ENTRY_W +: ENTRY_W];
        logic unused_st;
        assign unused_st = ^stage;
      end else begin : g_nrb
        assign src = stage;
        logic unused_rd;
        assign unused_rd = ^ram_rdata[g*ENTRY_W +: ENTRY_W];
      end

      assign wide    = 64'(src);
      assign lo_v[g] = wide[31:0];
      assign hi_v[g] = wide[63:32];
    end
  endgenerate

  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      OFS_ID:    rd_nxt = BLOCK_ID;
      OFS_VER:   rd_nxt = BLOCK_VER;
      OFS_PIX:   rd_nxt = 32'(PIX_PAR);
      OFS_IBPS:  rd_nxt = 32'(IN_BPS);
      OFS_OBPS:  rd_nxt = 32'(OUT_BPS);
      OFS_ALPHA: rd_nxt = 32'(ALPHA);
      OFS_DEPTH: rd_nxt = 32'(DEPTH);
      OFS_DIM:   rd_nxt = 32'(DIM);
      OFS_DBUF:  rd_nxt = 32'(DOUBLE_BUF);
      OFS_RDBK:  rd_nxt = 32'(READBACK);
      OFS_CTRL:  rd_nxt = {30'b0, sel, en};
      default: begin
        if (dec.is_ram) begin
          for (int k = 0; k < NRAM; k++) begin
            if (dec.idx == 3'(k)) begin
              case (dec.slot)
                SLOT_CMD: rd_nxt = 32'(eaddr[k]);
                SLOT_LO:  rd_nxt = lo_v[k];
                SLOT_HI:  rd_nxt = hi_v[k];
                default:  rd_nxt = '0;
              endcase
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_read ? rd_nxt : 32'd0;
  end
endmodule

// File: rtl/lutp_chk.sv
module lutp_chk #(
  parameter int NRAM       = 8,
  parameter int RAM_AW     = 6,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int RA_W = RAM_AW + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [8:0]           reg_addr,
  input logic                 reg_write,
  input logic [31:0]          reg_wdata,
  input logic                 sof,
  input logic                 tbl_enable,
  input logic                 tbl_active_buf,
  input logic [NRAM-1:0]      ram_we,
  input logic [NRAM*RA_W-1:0] ram_waddr
);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ram_we));

  assert_enable_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_write && reg_addr == 9'h148) |=> (tbl_enable == $past(reg_wdata[0])));

  assert_swap_at_sof_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(tbl_active_buf) |-> $past(sof));

  assert_single_copy_R11: assert property (@(posedge clk) disable iff (rst)
    !DOUBLE_BUF |-> !tbl_active_buf);

  generate
    for (genvar g = 0; g < NRAM; g++) begin : g_chk
      localparam logic [8:0] CMD_OFS = 9'h180 + 9'(16 * g);

      assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (rst)
        ram_we[g] |-> $past(reg_write && reg_addr == CMD_OFS && reg_wdata[28]));

      assert_inactive_copy_R9: assert property (@(posedge clk) disable iff (rst)
        ram_we[g] |-> (ram_waddr[g*RA_W + RAM_AW] == (DOUBLE_BUF && !$past(tbl_active_buf))));
    end
  endgenerate

  logic unused_chk;
  assign unused_chk = ^{reg_wdata, ram_waddr};
endmodule

bind lut_prog_regs lutp_chk #(
  .NRAM(NRAM), .RAM_AW(RAM_AW), .DOUBLE_BUF(DOUBLE_BUF)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_write(reg_write),
  .reg_wdata(reg_wdata), .sof(sof), .tbl_enable(tbl_enable),
  .tbl_active_buf(tbl_active_buf), .ram_we(ram_we), .ram_waddr(ram_waddr)
);

// File: tb/tb_lut_prog_regs.sv
`timescale 1ns/1ps
module tb_lut_prog_regs;
  localparam int NR  = 8;
  localparam int RAW = 6;
  localparam int EW  = 36;  // (0+3)*12
  localparam int EWB = 30;  // (0+3)*10, second build
  localparam int RW  = RAW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [8:0]  reg_addr = '0;
  logic        reg_write = 1'b0, reg_read = 1'b0, sof = 1'b0;
  logic [31:0] reg_wdata = '0;

  logic [31:0]        rdata, rdata_b;
  logic               en, act, en_b, act_b;
  logic [NR-1:0]      we, we_b;
  logic [NR*RW-1:0]   waddr, raddr, waddr_b, raddr_b;
  logic [NR*EW-1:0]   wdata, ram_rdata;
  logic [NR*EWB-1:0]  wdata_b;

  lut_prog_regs dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_write(reg_write),
    .reg_read(reg_read), .reg_wdata(reg_wdata), .reg_rdata(rdata), .sof(sof),
    .tbl_enable(en), .tbl_active_buf(act), .ram_we(we), .ram_waddr(waddr),
    .ram_wdata(wdata), .ram_raddr(raddr), .ram_rdata(ram_rdata));

  lut_prog_regs #(.DEPTH(10), .DOUBLE_BUF(1'b0), .READBACK(1'b0)) dut_b (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_write(reg_write),
    .reg_read(reg_read), .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .sof(sof),
    .tbl_enable(en_b), .tbl_active_buf(act_b), .ram_we(we_b), .ram_waddr(waddr_b),
    .ram_wdata(wdata_b), .ram_raddr(raddr_b), .ram_rdata('0));

  // external sub-RAMs: one write port, one read port, one cycle of latency
  logic [EW-1:0] env_mem [2][NR][64];
  always @(posedge clk) begin
    for (int n = 0; n < NR; n++) begin
      if (we[n]) env_mem[waddr[n*RW+RAW]][n][waddr[n*RW +: RAW]] <= wdata[n*EW +: EW];
      ram_rdata[n*EW +: EW] <= env_mem[raddr[n*RW+RAW]][n][raddr[n*RW +: RAW]];
    end
  end

  // behavioural reference of the default build
  bit          m_en, m_sel, m_act;
  int          m_we;
  logic [6:0]  m_waddr;
  logic [35:0] m_wd;
  logic [31:0] m_lo [NR];
  logic [3:0]  m_hi [NR];
  logic [16:0] m_ea [NR];
  logic [35:0] ref_mem [2][NR][64];

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_sel <= 0; m_act <= 0; m_we <= -1;
      for (int n = 0; n < NR; n++) begin m_lo[n] <= '0; m_hi[n] <= '0; m_ea[n] <= '0; end
    end else begin
      int cb;
      cb = m_act ? 0 : 1;
      m_we <= -1;
      if (reg_write) begin
        if (reg_addr == 9'h148) begin m_en <= reg_wdata[0]; m_sel <= reg_wdata[1]; end
        for (int n = 0; n < NR; n++) begin
          int base;
          base = 'h180 + 16 * n;
          if (reg_addr == 9'(base)) begin
            m_ea[n] <= reg_wdata[16:0];
            if (reg_wdata[28]) begin
              m_we    <= n;
              m_waddr <= {1'(cb), reg_wdata[5:0]};
              m_wd    <= {m_hi[n], m_lo[n]};
              ref_mem[cb][n][reg_wdata[5:0]] <= {m_hi[n], m_lo[n]};
            end
          end
          if (reg_addr == 9'(base + 8))  m_lo[n] <= reg_wdata;
          if (reg_addr == 9'(base + 12)) m_hi[n] <= reg_wdata[3:0];
        end
      end
      if (sof) m_act <= m_sel;
    end
  end

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NR-1:0] ewe;
      ewe = (m_we >= 0) ? NR'(1 << m_we) : '0;
      chk("R3 tbl_enable", 64'(en), 64'(m_en));
      chk("R4 tbl_active_buf", 64'(act), 64'(m_act));
      chk("R5 ram_we", 64'(we), 64'(ewe));
      chk("R11 single-copy active", 64'(act_b), 64'd0);
      if (m_we >= 0) begin
        chk("R9 write address", 64'(waddr[m_we*RW +: RW]), 64'(m_waddr));
        chk("R5 write data", 64'(wdata[m_we*EW +: EW]), 64'(m_wd));
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    reg_read = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_read = 1'b0;
    chk(tag, 64'(rdata), 64'(e));
  endtask

  task automatic rd_b(input logic [8:0] a, input logic [31:0] e, input string tag);
    reg_read = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_read = 1'b0;
    chk(tag, 64'(rdata_b), 64'(e));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  function automatic logic [31:0] rb_lo(input int n);
    logic [35:0] v;
    v = ref_mem[m_act ? 0 : 1][n][m_ea[n][5:0]];
    return v[31:0];
  endfunction

  function automatic logic [31:0] rb_hi(input int n);
    logic [35:0] v;
    v = ref_mem[m_act ? 0 : 1][n][m_ea[n][5:0]];
    return {28'd0, v[35:32]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 enable", 64'(en), 0);
    chk("R1 active", 64'(act), 0);
    chk("R1 strobes", 64'(we), 0);
    chk("R1 rdata", 64'(rdata), 0);
    rd(9'h148, 32'h0, "R1 control word");

    // R2 build settings
    rd(9'h000, 32'h3D1C_0A00, "R2 id");
    rd(9'h004, 32'h0001_0002, "R2 version");
    rd(9'h00C, 1, "R2 pixels");
    rd(9'h010, 10, "R2 in bps");
    rd(9'h014, 10, "R2 out bps");
    rd(9'h018, 0, "R2 alpha");
    rd(9'h01C, 12, "R2 depth");
    rd(9'h020, 17, "R2 size");
    rd(9'h024, 1, "R2 double");
    rd(9'h028, 1, "R2 readback");

    // R10 reserved and read-only
    wr(9'h01C, 32'hFF);
    wr(9'h000, 32'h0);
    wr(9'h184, 32'hFFFF_FFFF);
    wr(9'h14C, 32'hFFFF_FFFF);
    rd(9'h01C, 12, "R10 RO depth kept");
    rd(9'h000, 32'h3D1C_0A00, "R10 RO id kept");
    rd(9'h184, 0, "R10 reserved slot");
    rd(9'h14C, 0, "R10 reserved gap");
    rd(9'h008, 0, "R10 reserved 0x008");
    rd(9'h100, 0, "R10 reserved 0x100");

    // R3 control
    wr(9'h148, 32'hFFFF_FFFD);
    rd(9'h148, 32'h1, "R3 control read");
    idle(1);
    chk("R12 rdata idle zero", 64'(rdata), 0);

    // R5/R7 stage and commit on sub-RAM 0, entry 5, copy 1
    wr(9'h188, 32'hA5A5_1234);
    wr(9'h18C, 32'hFFFF_FFF9);
    wr(9'h180, 32'h1000_0005);
    chk("R5 strobe high", 64'(we), 64'h1);
    chk("R9 copy bit 1", 64'(waddr[RAW]), 1);
    chk("R11 single-copy bit 0", 64'(waddr_b[RAW]), 0);
    chk("R11 single-copy strobe", 64'(we_b), 64'h1);
    idle(1);
    chk("R5 strobe one cycle", 64'(we), 0);
    rd(9'h180, 32'h5, "R6 index kept, commit bit reads 0");
    wr(9'h190, 32'hE7FF_FFFF);
    rd(9'h190, 32'h1_FFFF, "R6 index field only");
    idle(3);
    rd(9'h188, 32'hA5A5_1234, "R8 readback low");
    rd(9'h18C, 32'h9, "R7 high word masked");

    // sub-RAM 7, last entry
    wr(9'h1F8, 32'h1357_9BDF);
    wr(9'h1FC, 32'h6);
    wr(9'h1F0, 32'h1000_003F);
    idle(3);
    rd(9'h1F8, rb_lo(7), "R8 readback ram7 low");
    rd(9'h1FC, rb_hi(7), "R8 readback ram7 high");

    // R4 copy swap only at frame start
    wr(9'h148, 32'h3);
    idle(2);
    chk("R4 held before sof", 64'(act), 0);
    pulse_sof();
    chk("R4 swapped after sof", 64'(act), 1);
    chk("R11 single copy stays 0", 64'(act_b), 0);

    // R9 commits now aim at copy 0
    wr(9'h188, 32'h0BAD_F00D);
    wr(9'h18C, 32'h3);
    wr(9'h180, 32'h1000_0005);
    chk("R9 copy bit 0", 64'(waddr[RAW]), 0);
    idle(3);
    rd(9'h188, 32'h0BAD_F00D, "R9 readback copy 0");
    rd(9'h18C, 32'h3, "R9 readback copy 0 high");
    pulse_sof();
    chk("R4 no change with same select", 64'(act), 1);
    wr(9'h148, 32'h1);
    idle(2);
    chk("R4 held without sof", 64'(act), 1);
    pulse_sof();
    chk("R4 back to copy 0", 64'(act), 0);
    idle(2);
    rd(9'h188, 32'hA5A5_1234, "R9 readback copy 1 again");

    // R11/R7 second build: staged readback, 30-bit entries
    wr(9'h1A8, 32'hFFFF_FFFF);
    wr(9'h1AC, 32'hF);
    rd_b(9'h1A8, 32'h3FFF_FFFF, "R11 staged low masked");
    rd_b(9'h1AC, 32'h0, "R7 high word absent");
    rd_b(9'h188, 32'h0BAD_F00D, "R11 staged low ram0");
    rd_b(9'h024, 0, "R2 double off");

    idle(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule